// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This block sits on the host side of a parallel flash interface and decides when a program or erase operation inside the device has finished. After the operation has been started by other logic, a pulse on `start_i` arms the poller. It then reads the device status byte at a fixed poll address through a request/acknowledge bus port. A status bit that the device inverts on every read while it is busy is compared across each pair of back-to-back reads. An unchanged bit means the operation has ended.

A second status bit is the device's timeout flag. When the toggle is still active and that flag is set, the poller does not fail straight away, because the toggling can stop in the same read that raises the flag. It takes one more pair of reads first. Only if that pair still toggles does it write the reset command to the device and report failure. A programmable round limit gives an independent failure path for operations that never settle. The result comes out as a one-cycle `done_o` or `fail_o` pulse. `busy_o` covers the whole run before that pulse.

Top module: `toggle_poll_ctrl`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `fail_o` and `bus_req_o` are all low, and the block stays idle until `start_i` is seen.
- R2: A `start_i` pulse while idle makes `busy_o` high from the next cycle. `busy_o` stays high until the cycle of the result pulse, where it is low. A `start_i` while busy is ignored and starts no second run.
- R3: Each poll round issues two reads (`bus_we_o`=0) at `poll_addr_i`. `bus_req_o` holds its request, with its direction and address unchanged, until `bus_ack_i` is high. Read data is taken in the acknowledge cycle.
- R4: If the compared toggle bit has the same value in both reads of a round, the block pulses `done_o` and writes nothing.
- R5: If the bit differs and bit 5 (timeout flag) of the second read is 0, the block starts another round of two reads.
- R6: If the bit differs and bit 5 of the second read is 1, the block takes two further reads. If the bit still differs across them, the block writes data 0xF0 to `poll_addr_i` (`bus_we_o`=1) and pulses `fail_o` in the cycle after that write is acknowledged.
- R7: If the bit does not differ across the recheck reads of R6, the block pulses `done_o` with no write, even though the timeout flag was set.
- R8: `use_alt_i`, sampled at start, selects the compared bit. A value of 0 selects bit 6 and a value of 1 selects bit 2. The unselected bit has no effect.
- R9: `max_rounds_i`, sampled at start, limits the number of rounds. When the round with that number still toggles with bit 5 at 0, the block writes 0xF0 and pulses `fail_o`. A value of 0 acts as 1.
- R10: `done_o` and `fail_o` are never high together. Each is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Arms a polling run when idle |
| use_alt_i | input | 1 | Toggle bit select: 0 = bit 6, 1 = bit 2 |
| poll_addr_i | input | ADDR_W | Valid address used for reads and the reset write |
| max_rounds_i | input | CNT_W | Maximum number of read pairs before forced failure |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Write data (reset command) |
| bus_ack_i | input | 1 | Transaction acknowledge, one cycle |
| bus_rdata_i | input | DATA_W | Read data, valid with acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |

## Verification
The embedded properties check on every cycle that the request is held stable until it is acknowledged, that the result pulses exclude each other and last one cycle, that a failure is always preceded by an acknowledged write, that an idle start raises busy, and that the round counter never wraps. Only the directed scenarios can show the decision path itself. That covers which byte sequence gives success or failure, how many reads and writes each path costs, the recheck after the timeout flag, the effect of the bit select, and the round limit.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_RD_A,
      ST_RD_B,
      ST_EVAL,
      ST_CK_A,
      ST_CK_B,
      ST_CK_EVAL,
      ST_ABORT,
      ST_DONE,
      ST_FAIL
   } tbp_state_e;
endpackage

// File: rtl/tbp_toggle_cmp.sv
module tbp_toggle_cmp #(
   parameter int DATA_W    = 8,
   parameter int TOG_A_BIT = 6,
   parameter int TOG_B_BIT = 2,
   parameter int TMO_BIT   = 5
) (
   input  logic [DATA_W-1:0] first_i,
   input  logic [DATA_W-1:0] second_i,
   input  logic              use_alt_i,
   output logic              toggled_o,
   output logic              timeout_o
);
   if (TOG_A_BIT >= DATA_W || TOG_B_BIT >= DATA_W || TMO_BIT >= DATA_W) begin : g_bad_bit
      $error("tbp_toggle_cmp: status bit index outside data width");
   end

   logic diff_a;
   logic diff_b;
   assign diff_a = first_i[TOG_A_BIT] ^ second_i[TOG_A_BIT];
   assign diff_b = first_i[TOG_B_BIT] ^ second_i[TOG_B_BIT];

   if (TOG_A_BIT == TOG_B_BIT) begin : g_single
      logic unused_sel;
      assign unused_sel = use_alt_i ^ diff_b;
      assign toggled_o  = diff_a;
   end else begin : g_dual
      assign toggled_o = use_alt_i ? diff_b : diff_a;
   end

   assign timeout_o = second_i[TMO_BIT];
endmodule

// File: rtl/tbp_round_cnt.sv
module tbp_round_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             inc_i,
   input  logic [CNT_W-1:0] limit_i,
   output logic             last_o
);
   if (CNT_W < 2) begin : g_bad_w
      $error("tbp_round_cnt: CNT_W must be at least 2");
   end

   localparam int EXT_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [EXT_W-1:0] rounds_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (inc_i)  cnt_q <= cnt_q + 1'b1;
   end

   assign rounds_now = {1'b0, cnt_q} + 1'b1;
   assign last_o     = rounds_now >= {1'b0, limit_i};

   assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      inc_i |-> cnt_q != {CNT_W{1'b1}});
   assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> !last_o || limit_i <= 1);
endmodule

// File: rtl/toggle_poll_ctrl.sv
module toggle_poll_ctrl
   import tbp_pkg::*;
#(
   parameter int          ADDR_W    = 24,
   parameter int          DATA_W    = 8,
   parameter int          CNT_W     = 16,
   parameter int          TOG_A_BIT = 6,
   parameter int          TOG_B_BIT = 2,
   parameter int          TMO_BIT   = 5,
   parameter logic [7:0]  RST_CMD   = 8'hF0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              use_alt_i,
   input  logic [ADDR_W-1:0] poll_addr_i,
   input  logic [CNT_W-1:0]  max_rounds_i,
   output logic              bus_req_o,
   output logic              bus_we_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              fail_o
);
   if (DATA_W < 8) begin : g_bad_data
      $error("toggle_poll_ctrl: DATA_W must be at least 8");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("toggle_poll_ctrl: ADDR_W must be positive");
   end

   localparam int PAD_W = DATA_W - 8;

   tbp_state_e        state_q, state_d;
   logic [DATA_W-1:0] first_q, second_q;
   logic              alt_q;
   logic [CNT_W-1:0]  limit_q;
   logic [ADDR_W-1:0] addr_q;
   logic              toggled, timeout, last_round;
   logic              cnt_clr, cnt_inc;
   logic              idle_start;

   assign idle_start = (state_q == ST_IDLE) && start_i;

   tbp_toggle_cmp #(
      .DATA_W(DATA_W), .TOG_A_BIT(TOG_A_BIT), .TOG_B_BIT(TOG_B_BIT), .TMO_BIT(TMO_BIT)
   ) u_cmp (
      .first_i  (first_q),
      .second_i (second_q),
      .use_alt_i(alt_q),
      .toggled_o(toggled),
      .timeout_o(timeout)
   );

   tbp_round_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr_i  (cnt_clr),
      .inc_i  (cnt_inc),
      .limit_i(limit_q),
      .last_o (last_round)
   );

   always_comb begin
      state_d = state_q;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            state_d = ST_RD_A;
            cnt_clr = 1'b1;
         end
         ST_RD_A: if (bus_ack_i) state_d = ST_RD_B;
         ST_RD_B: if (bus_ack_i) state_d = ST_EVAL;
         ST_EVAL: begin
            if (!toggled)        state_d = ST_DONE;
            else if (timeout)    state_d = ST_CK_A;
            else if (last_round) state_d = ST_ABORT;
            else begin
               state_d = ST_RD_A;
               cnt_inc = 1'b1;
            end
         end
         ST_CK_A: if (bus_ack_i) state_d = ST_CK_B;
         ST_CK_B: if (bus_ack_i) state_d = ST_CK_EVAL;
         ST_CK_EVAL: state_d = toggled ? ST_ABORT : ST_DONE;
         ST_ABORT: if (bus_ack_i) state_d = ST_FAIL;
         ST_DONE:  state_d = ST_IDLE;
         ST_FAIL:  state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         first_q  <= '0;
         second_q <= '0;
         alt_q    <= 1'b0;
         limit_q  <= '0;
         addr_q   <= '0;
      end else begin
         state_q <= state_d;
         if (idle_start) begin
            alt_q   <= use_alt_i;
            limit_q <= max_rounds_i;
            addr_q  <= poll_addr_i;
         end
         if (bus_ack_i && (state_q == ST_RD_A || state_q == ST_CK_A)) first_q  <= bus_rdata_i;
         if (bus_ack_i && (state_q == ST_RD_B || state_q == ST_CK_B)) second_q <= bus_rdata_i;
      end
   end

   always_comb begin
      bus_req_o = 1'b0;
      bus_we_o  = 1'b0;
      unique case (state_q)
         ST_RD_A, ST_RD_B, ST_CK_A, ST_CK_B: bus_req_o = 1'b1;
         ST_ABORT: begin
            bus_req_o = 1'b1;
            bus_we_o  = 1'b1;
         end
         default: ;
      endcase
   end

   assign bus_addr_o = addr_q;
   if (PAD_W > 0) begin : g_pad
      assign bus_wdata_o = {{PAD_W{1'b0}}, RST_CMD};
   end else begin : g_nopad
      assign bus_wdata_o = RST_CMD;
   end

   assign busy_o = !(state_q == ST_IDLE || state_q == ST_DONE || state_q == ST_FAIL);
   assign done_o = state_q == ST_DONE;
   assign fail_o = state_q == ST_FAIL;

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_o && !bus_ack_i |=> bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o));
   assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o && !done_o && !fail_o |=> busy_o);
   assert_fail_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> $past(bus_req_o && bus_we_o && bus_ack_i));
   assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && fail_o));
   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   assert_fail_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |=> !fail_o);
   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !bus_req_o);
endmodule

// File: tb/toggle_poll_ctrl_tb.sv
module toggle_poll_ctrl_tb;
   localparam int ADDR_W = 24;
   localparam int DATA_W = 8;
   localparam int CNT_W  = 16;
   localparam logic [ADDR_W-1:0] PADDR = 24'h03_A5C0;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start_i = 1'b0;
   logic              use_alt_i = 1'b0;
   logic [ADDR_W-1:0] poll_addr_i = PADDR;
   logic [CNT_W-1:0]  max_rounds_i = 16'd100;
   logic              bus_req_o, bus_we_o;
   logic [ADDR_W-1:0] bus_addr_o;
   logic [DATA_W-1:0] bus_wdata_o;
   logic              bus_ack_i = 1'b0;
   logic [DATA_W-1:0] bus_rdata_i = '0;
   logic              busy_o, done_o, fail_o;

   int errors = 0;
   int checks = 0;
   logic [7:0] scr [0:15];
   int rd_idx = 0, rd_cnt = 0, wr_cnt = 0, addr_bad = 0;
   logic [7:0] wdata_l = '0;

   always #2 clk = ~clk;

   toggle_poll_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .use_alt_i(use_alt_i),
      .poll_addr_i(poll_addr_i), .max_rounds_i(max_rounds_i),
      .bus_req_o(bus_req_o), .bus_we_o(bus_we_o), .bus_addr_o(bus_addr_o),
      .bus_wdata_o(bus_wdata_o), .bus_ack_i(bus_ack_i), .bus_rdata_i(bus_rdata_i),
      .busy_o(busy_o), .done_o(done_o), .fail_o(fail_o));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bus responder: one-cycle acknowledge for every request
   initial begin
      forever begin
         @(negedge clk);
         if (bus_ack_i) bus_ack_i = 1'b0;
         else if (bus_req_o) begin
            bus_ack_i = 1'b1;
            if (bus_addr_o != PADDR) addr_bad++;
            if (bus_we_o) begin
               wr_cnt++;
               wdata_l = bus_wdata_o;
            end else begin
               bus_rdata_i = scr[rd_idx];
               if (rd_idx < 15) rd_idx++;
               rd_cnt++;
            end
         end
      end
   end

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   task automatic load4(input logic [7:0] a, b, c, d);
      for (int i = 0; i < 16; i++) scr[i] = d;
      scr[0] = a; scr[1] = b; scr[2] = c; scr[3] = d;
   endtask

   // runs one poll and checks outcome, read/write counts, busy and pulse shape
   task automatic run(input bit alt, input logic [CNT_W-1:0] maxr, input bit exp_fail,
                      input int exp_rd, input int exp_wr, input string req, input bit mid_start);
      bit seen_done, seen_fail, busy_drop;
      int k;
      rd_idx = 0; rd_cnt = 0; wr_cnt = 0; addr_bad = 0; wdata_l = '0;
      seen_done = 0; seen_fail = 0; busy_drop = 0;
      @(negedge clk);
      use_alt_i = alt; max_rounds_i = maxr; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; use_alt_i = ~alt; max_rounds_i = 16'd1;
      check(busy_o == 1'b1, "R2 busy after start", busy_o, 1);
      k = 0;
      while (!done_o && !fail_o && k < 400) begin
         @(negedge clk);
         k++;
         if (mid_start && k == 3) start_i = 1'b1;
         else start_i = 1'b0;
         if (!done_o && !fail_o && !busy_o) busy_drop = 1;
      end
      seen_done = done_o; seen_fail = fail_o;
      check(!busy_drop, {req, " busy held"}, busy_drop, 0);
      check(busy_o == 1'b0, "R2 busy low at pulse", busy_o, 0);
      check(seen_fail == exp_fail && seen_done == !exp_fail, {req, " outcome fail"}, seen_fail, exp_fail);
      @(negedge clk);
      check(!done_o && !fail_o, "R10 single-cycle pulse", done_o | fail_o, 0);
      check(rd_cnt == exp_rd, {req, " reads"}, rd_cnt, exp_rd);
      check(wr_cnt == exp_wr, {req, " writes"}, wr_cnt, exp_wr);
      if (exp_wr > 0) check(wdata_l == 8'hF0, "R6 reset data", wdata_l, 8'hF0);
      check(addr_bad == 0, "R3 address", addr_bad, 0);
      repeat (10) @(negedge clk);
      check(rd_cnt == exp_rd && !busy_o, "R2 no second run", rd_cnt, exp_rd);
   endtask

   task automatic t_reset;
      check(busy_o == 0 && done_o == 0 && fail_o == 0, "R1 status idle", busy_o, 0);
      check(bus_req_o == 0, "R1 no request", bus_req_o, 0);
      repeat (3) @(negedge clk);
      check(rd_cnt == 0, "R1 stays idle", rd_cnt, 0);
   endtask

   task automatic t_stable;   load4(8'h40, 8'h40, 8'h40, 8'h40); run(0, 16'd100, 0, 2, 0, "R4", 0); endtask
   task automatic t_loop;     load4(8'h00, 8'h40, 8'h40, 8'h40); run(0, 16'd100, 0, 4, 0, "R5", 0); endtask
   task automatic t_tmo_fail; load4(8'h00, 8'h60, 8'h20, 8'h60); run(0, 16'd100, 1, 4, 1, "R6", 0); endtask
   task automatic t_tmo_ok;   load4(8'h00, 8'h60, 8'h60, 8'h60); run(0, 16'd100, 0, 4, 0, "R7", 0); endtask
   task automatic t_alt_ign;  load4(8'h00, 8'h40, 8'h40, 8'h40); run(1, 16'd100, 0, 2, 0, "R8 bit6 ignored", 0); endtask
   task automatic t_alt_loop; load4(8'h04, 8'h00, 8'h04, 8'h04); run(1, 16'd100, 0, 4, 0, "R8 bit2 toggles", 0); endtask
   task automatic t_mid;      load4(8'h00, 8'h40, 8'h40, 8'h40); run(0, 16'd100, 0, 4, 0, "R2 start ignored", 1); endtask

   task automatic t_limit;
      for (int i = 0; i < 16; i++) scr[i] = (i % 2) ? 8'h40 : 8'h00;
      run(0, 16'd3, 1, 6, 1, "R9 limit 3", 0);
      for (int i = 0; i < 16; i++) scr[i] = (i % 2) ? 8'h40 : 8'h00;
      run(0, 16'd0, 1, 2, 1, "R9 limit 0", 0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) scr[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_stable();
      t_loop();
      t_tmo_fail();
      t_tmo_ok();
      t_alt_ign();
      t_alt_loop();
      t_mid();
      t_limit();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule